// File: doc/BRIEF.md
# GPIO Edge-to-Interrupt Aggregator

This block watches sixteen general-purpose input lines and converts selected transitions or levels on them into interrupt requests. Each line is first brought into the local clock domain by a two-flop synchroniser. It then passes through a per-line detector that can watch for a rising edge, a falling edge, either edge or a low level. A hit sets a sticky pending bit that only software can clear, by writing a one to it.

The sixteen pending bits, gated by a per-line enable mask, are folded onto seven registered request outputs. The five lowest lines each own a request output. Lines 5 to 9 share one output, and lines 10 to 15 share another. A handler for a shared output reads the pending register to learn which lines fired. Every line that has fired stays visible there until it is cleared. A small register port gives access to the sensitivity codes, the mask and the pending bits. Read data appears one cycle after the read strobe.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: Request output `irq_line_o[k]` for k = 0..4 is high exactly when pending bit k and mask bit k are both 1, one cycle after the pending bit and the mask reach that state.
- R2: `irq_grp_lo_o` is high while any of lines 5..9 has both its pending bit and its mask bit set, and it stays high until the last such bit is cleared.
- R3: `irq_grp_hi_o` is the same combination for lines 10..15.
- R4: A read at address 2 returns the pending bits in data bits [15:0], with bit k for line k. Several bits can be set at once, and all of them are shown.
- R5: Line k uses a 2-bit sensitivity code in bits [2k+1:2k] of the register at address 0. Code 11 makes a 0-to-1 transition set the pending bit.
- R6: Code 10 makes a 1-to-0 transition set the pending bit. A 0-to-1 transition has no effect.
- R7: Code 01 makes either transition set the pending bit.
- R8: Code 00 sets the pending bit on every cycle in which the synchronised line is low.
- R9: Mask bit k sits in bits [15:0] of the register at address 1. While it is 0, line k still latches its pending bit but raises no request. Setting the mask bit later raises the request for a bit that is already pending.
- R10: Writing address 2 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R11: If a detector hit and a clear of the same bit fall in the same cycle, the bit ends up set.
- R12: After an input transition, the matching request output goes high on the fourth rising clock edge, counting the edge that first samples the new value. It is still low after the third edge.
- R13: After reset, every sensitivity code is 11, the mask is 0, every pending bit is 0 and every request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_i | input | 16 | Asynchronous input lines |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 2 | Register address: 0 sensitivity, 1 mask, 2 pending |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| irq_line_o | output | 5 | Dedicated requests for lines 0..4 |
| irq_grp_lo_o | output | 1 | Shared request for lines 5..9 |
| irq_grp_hi_o | output | 1 | Shared request for lines 10..15 |

## Verification
Two things can act on the same pending bit in one cycle: a detector hit that sets it and a software write that clears it. The bench first leaves line 10 pending and lets it fall. It then raises the line again and issues the clear two cycles later, so that the write lands on the same clock edge as the new rising edge coming out of the synchroniser. A read-back of the pending register that still shows the bit counts as a pass. The low-level mode creates the same collision in steady state: a clear written while the line is held low must not stick.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    SENS_LOW  = 2'b00,
    SENS_BOTH = 2'b01,
    SENS_FALL = 2'b10,
    SENS_RISE = 2'b11
  } sens_e;

  localparam logic [1:0] ADDR_SENS = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_PEND = 2'd2;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[k] <= '0;
        else     stage_q[k] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[k] <= '0;
        else     stage_q[k] <= stage_q[k-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_i,
  input  logic [1:0] sens_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic prev_q;
  logic pend_q;
  logic hit;

  always_comb begin
    case (sens_e'(sens_i))
      SENS_RISE: hit = sync_i & ~prev_q;
      SENS_FALL: hit = ~sync_i & prev_q;
      SENS_BOTH: hit = sync_i ^ prev_q;
      SENS_LOW:  hit = ~sync_i;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (hit)        pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R11: a hit wins against a clear in the same cycle
  p_hit_sets_r11: assert property (@(posedge clk) disable iff (rst)
    hit |=> pend_q);

  // R10: a clear with no hit empties the bit
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit) |=> !pend_q);

  // R10: without a hit or a clear the bit holds
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !hit) |=> $stable(pend_q));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [LINES-1:0]     pend_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [2*LINES-1:0]   sens_o,
  output logic [LINES-1:0]     mask_o,
  output logic [LINES-1:0]     clr_o
);
  localparam int SW = 2 * LINES;

  logic [SW-1:0]     sens_q;
  logic [LINES-1:0]  mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_SENS: rd_mux[SW-1:0]    = sens_q;
      ADDR_MASK: rd_mux[LINES-1:0] = mask_q;
      ADDR_PEND: rd_mux[LINES-1:0] = pend_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sens_q  <= '1;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && addr_i == ADDR_SENS) sens_q <= wdata_i[SW-1:0];
      if (wr_en && addr_i == ADDR_MASK) mask_q <= wdata_i[LINES-1:0];
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign clr_o   = (wr_en && addr_i == ADDR_PEND) ? wdata_i[LINES-1:0] : '0;
  assign sens_o  = sens_q;
  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  // R4: a pending read returns the bits present at the strobe
  p_read_pend_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr_i == ADDR_PEND) |=> rdata_o[LINES-1:0] == $past(pend_i));

  // R9: a mask write lands in the next cycle
  p_mask_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_i == ADDR_MASK) |=> mask_o == $past(wdata_i[LINES-1:0]));
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int LINES   = 16,
  parameter int DED     = 5,
  parameter int LO_LAST = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] mask_i,
  output logic [DED-1:0]   irq_ded_o,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);
  localparam int HI_FIRST = LO_LAST + 1;

  logic [LINES-1:0] live;
  logic [DED-1:0]   ded_q;
  logic             lo_q;
  logic             hi_q;

  assign live = pend_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ded_q <= '0;
      lo_q  <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      ded_q <= live[DED-1:0];
      lo_q  <= |live[LO_LAST:DED];
      hi_q  <= |live[LINES-1:HI_FIRST];
    end
  end

  assign irq_ded_o = ded_q;
  assign irq_lo_o  = lo_q;
  assign irq_hi_o  = hi_q;

  // R1: each dedicated output follows its own line
  p_dedicated_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_ded_o == $past(pend_i[DED-1:0] & mask_i[DED-1:0]));

  // R2: the low shared output is held by any live line of its group
  p_group_lo_r2: assert property (@(posedge clk) disable iff (rst)
    (|(pend_i[LO_LAST:DED] & mask_i[LO_LAST:DED])) |=> irq_lo_o);

  // R3: the high shared output is held by any live line of its group
  p_group_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (|(pend_i[LINES-1:HI_FIRST] & mask_i[LINES-1:HI_FIRST])) |=> irq_hi_o);

  // R9: a fully masked set of lines raises no request
  p_all_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> (irq_ded_o == '0 && !irq_lo_o && !irq_hi_o));
endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator #(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_DED     = 5,
  parameter int LO_LAST     = 9,
  parameter int DATA_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] gpio_i,
  input  logic                 cfg_wr_en,
  input  logic                 cfg_rd_en,
  input  logic [1:0]           cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic [NUM_DED-1:0]   irq_line_o,
  output logic                 irq_grp_lo_o,
  output logic                 irq_grp_hi_o
);
  localparam int SENS_W = 2 * NUM_LINES;

  logic [NUM_LINES-1:0] line_sync;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] mask;
  logic [NUM_LINES-1:0] clr;
  logic [SENS_W-1:0]    sens;

  gpio_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (gpio_i),
    .sync_o  (line_sync)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gpio_irq_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .sync_i (line_sync[i]),
      .sens_i (sens[2*i +: 2]),
      .clr_i  (clr[i]),
      .pend_o (pend[i])
    );
  end

  gpio_irq_regs #(.LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .rd_en   (cfg_rd_en),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .pend_i  (pend),
    .rdata_o (cfg_rdata),
    .sens_o  (sens),
    .mask_o  (mask),
    .clr_o   (clr)
  );

  gpio_irq_route #(.LINES(NUM_LINES), .DED(NUM_DED), .LO_LAST(LO_LAST)) u_route (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend),
    .mask_i    (mask),
    .irq_ded_o (irq_line_o),
    .irq_lo_o  (irq_grp_lo_o),
    .irq_hi_o  (irq_grp_hi_o)
  );

  // R13: reset leaves every request output low
  p_reset_quiet_r13: assert property (@(posedge clk)
    rst |=> (irq_line_o == '0 && !irq_grp_lo_o && !irq_grp_hi_o));
endmodule

// File: tb/tb_gpio_irq_aggregator.sv
module tb_gpio_irq_aggregator;
  localparam logic [1:0] A_SENS = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_PEND = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] gpio_i = '0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [4:0]  irq_line_o;
  logic        irq_grp_lo_o;
  logic        irq_grp_hi_o;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] sens_m = 32'hFFFF_FFFF;

  typedef struct {
    int          when;
    bit          is_rd;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  gpio_irq_aggregator dut (
    .clk(clk), .rst(rst), .gpio_i(gpio_i),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_line_o(irq_line_o), .irq_grp_lo_o(irq_grp_lo_o), .irq_grp_hi_o(irq_grp_hi_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items on their due cycle and compares
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].when <= cyc) begin
        logic [31:0] act;
        act = exp_q[i].is_rd ? cfg_rdata
                             : {25'd0, irq_grp_hi_o, irq_grp_lo_o, irq_line_o};
        checks++;
        if (exp_q[i].when != cyc || act !== exp_q[i].val) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h (cycle %0d)",
                   exp_q[i].tag, act, exp_q[i].val, cyc);
        end
        exp_q.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int dly, bit is_rd, logic [31:0] v, string tag);
    exp_t e;
    e.when = cyc + dly; e.is_rd = is_rd; e.val = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    step(1);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [31:0] v, string tag);
    cfg_addr = a; cfg_rd_en = 1'b1;
    push(1, 1'b1, v, tag);
    step(1);
    cfg_rd_en = 1'b0;
  endtask

  task automatic irq_chk(int dly, logic [6:0] v, string tag);
    push(dly, 1'b0, {25'd0, v}, tag);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step(1);
    step(1);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    step(1);

    // R13 reset state
    rd_chk(A_SENS, 32'hFFFF_FFFF, "R13 sens reset");
    rd_chk(A_MASK, 32'h0, "R13 mask reset");
    rd_chk(A_PEND, 32'h0, "R13 pend reset");
    irq_chk(1, 7'h00, "R13 irq reset");
    drain();

    wr(A_MASK, 32'h0000_FFFF);
    step(1);

    // R5 / R1 / R12: rising edge on line 2 and its latency
    gpio_i[2] = 1'b1;
    irq_chk(3, 7'h00, "R12 not before fourth edge");
    irq_chk(4, 7'h04, "R1 R5 R12 dedicated rise");
    drain();
    rd_chk(A_PEND, 32'h4, "R4 pend line 2");
    wr(A_PEND, 32'h0);
    rd_chk(A_PEND, 32'h4, "R10 zero write keeps bit");
    wr(A_PEND, 32'h4);
    irq_chk(1, 7'h00, "R10 clear drops request");
    drain();
    rd_chk(A_PEND, 32'h0, "R10 pend cleared");
    drain();

    // R2 / R4: two lines of the low group at once
    gpio_i[6] = 1'b1; gpio_i[8] = 1'b1;
    irq_chk(4, 7'h20, "R2 low group request");
    drain();
    rd_chk(A_PEND, 32'h140, "R4 both lines visible");
    wr(A_PEND, 32'h40);
    irq_chk(1, 7'h20, "R2 held by remaining line");
    drain();
    wr(A_PEND, 32'h100);
    irq_chk(1, 7'h00, "R2 released");
    drain();

    // R3: high group
    gpio_i[15] = 1'b1;
    irq_chk(4, 7'h40, "R3 high group request");
    drain();
    rd_chk(A_PEND, 32'h8000, "R3 R4 pend line 15");
    wr(A_PEND, 32'h8000);
    irq_chk(1, 7'h00, "R3 released");
    drain();

    // R6: falling edge on line 1
    sens_m[3:2] = 2'b10;
    wr(A_SENS, sens_m);
    step(1);
    gpio_i[1] = 1'b1;
    step(5);
    irq_chk(1, 7'h00, "R6 rise ignored");
    rd_chk(A_PEND, 32'h0, "R6 rise leaves pend clear");
    drain();
    gpio_i[1] = 1'b0;
    irq_chk(4, 7'h02, "R6 falling edge");
    drain();
    wr(A_PEND, 32'h2);
    step(2);

    // R7: both edges on line 3
    sens_m[7:6] = 2'b01;
    wr(A_SENS, sens_m);
    step(1);
    gpio_i[3] = 1'b1;
    irq_chk(4, 7'h08, "R7 rise");
    drain();
    wr(A_PEND, 32'h8);
    irq_chk(1, 7'h00, "R7 cleared");
    drain();
    gpio_i[3] = 1'b0;
    irq_chk(4, 7'h08, "R7 fall");
    drain();
    wr(A_PEND, 32'h8);
    step(2);

    // R9: masked line still latches
    wr(A_MASK, 32'h0000_FFEF);
    step(1);
    gpio_i[4] = 1'b1;
    step(5);
    irq_chk(1, 7'h00, "R9 masked no request");
    rd_chk(A_PEND, 32'h10, "R9 masked line latched");
    drain();
    wr(A_MASK, 32'h0000_FFFF);
    irq_chk(1, 7'h10, "R9 unmask raises request");
    drain();
    wr(A_PEND, 32'h10);
    step(2);

    // R11: new rising edge in the same cycle as the clear
    gpio_i[10] = 1'b1;
    irq_chk(4, 7'h40, "R3 line 10 request");
    drain();
    gpio_i[10] = 1'b0;
    step(4);
    gpio_i[10] = 1'b1;
    step(2);
    wr(A_PEND, 32'h400);
    rd_chk(A_PEND, 32'h400, "R11 edge beats clear");
    drain();
    wr(A_PEND, 32'h400);
    rd_chk(A_PEND, 32'h0, "R10 later clear works");
    drain();

    // R8: low level on line 0
    sens_m[1:0] = 2'b00;
    wr(A_SENS, sens_m);
    irq_chk(2, 7'h01, "R8 low level request");
    drain();
    wr(A_PEND, 32'h1);
    rd_chk(A_PEND, 32'h1, "R8 R11 level re-asserts");
    drain();
    gpio_i[0] = 1'b1;
    step(4);
    wr(A_PEND, 32'h1);
    rd_chk(A_PEND, 32'h0, "R8 high level releases");
    irq_chk(2, 7'h00, "R8 request gone");
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule